// File: doc/BRIEF.md
# Raster Video Timing Generator

This block produces the horizontal and vertical timing for a byte-oriented bitmap display. Time is counted in processor cycles rather than pixel clocks: a one-cycle-wide enable marks each processor cycle, and the generator advances its position only on those cycles. Each scan line is 65 cycles long. During the first 40 cycles of a line, one byte of 7 pixels is shown per cycle, which gives 280 visible pixels. The remaining 25 cycles of the line are horizontal blanking.

A frame is 262 lines, or 17030 cycles. Lines 0 to 191 are visible, which is 12480 cycles. Lines 192 to 261 form the vertical blanking interval, which is 4550 cycles.

The generator reports the byte column and the line number of the current position. It raises a blank flag for each axis, and it gives a single-cycle start-of-frame strobe. A memory fetch unit can use these outputs to address display memory. Software that wants tear-free updates can watch the vertical blank flag.

Top module: `raster_timing`

## Requirements
- R1: After a synchronous reset, the position is line 0, cycle 0: `hblank`=0, `vblank`=0, `col`=0, `line`=0.
- R2: While `cyc_en` is 0, no output changes, with one exception: `frame_start` follows `cyc_en` as stated in R8.
- R3: On each enabled cycle at positions 0 to 39 of a line, `hblank` is 0 and `col` equals the position. `col` therefore counts 0,1,…,39 over successive enabled cycles.
- R4: Positions 40 to 64 of a line, 25 enabled cycles, have `hblank`=1. `col` reads 0 during these positions.
- R5: The line number advances by one exactly when an enabled cycle occurs at position 64, and the horizontal position returns to 0 on that same cycle. A line therefore lasts 65 enabled cycles.
- R6: Lines 0 to 191 have `vblank`=0 and `line` equal to the line number. Lines 192 to 261 have `vblank`=1 and `line` reading 0, which makes 4550 enabled cycles of vertical blanking per frame.
- R7: Line 261 wraps to line 0. One frame is therefore exactly 17030 enabled cycles.
- R8: `frame_start` is 1 only while `cyc_en`=1 at line 0, position 0. It occurs once per frame.
- R9: Reset takes priority over `cyc_en`. While `rst` is 1 the position stays at line 0, position 0, whatever the enable does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | One pulse per processor cycle; position advances on enabled edges |
| hblank | output | 1 | High during the 25 non-visible cycles of a line |
| vblank | output | 1 | High during lines 192 to 261 |
| col | output | 6 | Byte column 0 to 39; reads 0 while `hblank` is 1 |
| line | output | 8 | Visible line 0 to 191; reads 0 while `vblank` is 1 |
| frame_start | output | 1 | High on the enabled cycle at line 0, position 0 |

## Verification
The flags, `col` and `line` are decoded without further registers from the position registers. They therefore reflect a rising edge with `cyc_en` high immediately after that edge. `frame_start` also depends on `cyc_en` in the same cycle.

The bench drives `rst` and `cyc_en` on the falling edge. One time unit later it compares every output against a behavioural model of the current position. It then steps the model as the next rising edge will, so each comparison is made half a clock after the edge that produced the state. Enables are irregular, which exercises holding (R2). Over more than two frames, the bench also measures the interval between frame strobes and the number of visible, horizontal-blank and vertical-blank cycles.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int unsigned LINE_CYC    = 65;
    localparam int unsigned VIS_BYTES   = 40;
    localparam int unsigned VIS_LINES   = 192;
    localparam int unsigned FRAME_LINES = 262;

    typedef struct packed {
        logic       hblank;
        logic       vblank;
        logic [5:0] col;
        logic [7:0] line;
        logic       frame_start;
    } raster_out_t;

    function automatic int unsigned frame_cycles(input int unsigned lc, input int unsigned fl);
        return lc * fl;
    endfunction

endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
    parameter int unsigned LINE_CYC = 65,
    localparam int unsigned H_W = $clog2(LINE_CYC)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cen,
    output logic [H_W-1:0] hpos,
    output logic           line_end
);
    localparam logic [H_W-1:0] H_LAST = H_W'(LINE_CYC - 1);

    logic [H_W-1:0] hpos_q;

    always_ff @(posedge clk) begin
        if (rst)
            hpos_q <= '0;
        else if (cen)
            hpos_q <= (hpos_q == H_LAST) ? '0 : hpos_q + 1'b1;
    end

    assign hpos     = hpos_q;
    assign line_end = (hpos_q == H_LAST);

    // R3/R4: position never leaves the line
    a_r4_h_in_range: assert property (@(posedge clk) disable iff (rst)
        hpos_q <= H_LAST);
    // R2: no movement without enable
    a_r2_h_hold: assert property (@(posedge clk) disable iff (rst)
        !cen |=> $stable(hpos_q));
    // R5: wrap to zero after the last position
    a_r5_h_wrap: assert property (@(posedge clk) disable iff (rst)
        (cen && hpos_q == H_LAST) |=> hpos_q == '0);
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
    parameter int unsigned FRAME_LINES = 262,
    localparam int unsigned V_W = $clog2(FRAME_LINES)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adv,
    output logic [V_W-1:0] vpos
);
    localparam logic [V_W-1:0] V_LAST = V_W'(FRAME_LINES - 1);

    logic [V_W-1:0] vpos_q;

    always_ff @(posedge clk) begin
        if (rst)
            vpos_q <= '0;
        else if (adv)
            vpos_q <= (vpos_q == V_LAST) ? '0 : vpos_q + 1'b1;
    end

    assign vpos = vpos_q;

    // R7: line number stays within the frame
    a_r7_v_in_range: assert property (@(posedge clk) disable iff (rst)
        vpos_q <= V_LAST);
    // R5: line holds unless advanced
    a_r5_v_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(vpos_q));
    // R7: last line returns to zero
    a_r7_v_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && vpos_q == V_LAST) |=> vpos_q == '0);
endmodule

// File: rtl/raster_decode.sv
module raster_decode #(
    parameter int unsigned VIS_BYTES = 40,
    parameter int unsigned VIS_LINES = 192,
    parameter int unsigned H_W = 7,
    parameter int unsigned V_W = 9
) (
    input  logic                    cen,
    input  logic [H_W-1:0]          hpos,
    input  logic [V_W-1:0]          vpos,
    output raster_pkg::raster_out_t tout
);
    localparam logic [H_W-1:0] H_VIS = H_W'(VIS_BYTES);
    localparam logic [V_W-1:0] V_VIS = V_W'(VIS_LINES);

    logic h_act, v_act;

    always_comb begin
        h_act            = (hpos < H_VIS);
        v_act            = (vpos < V_VIS);
        tout.hblank      = !h_act;
        tout.vblank      = !v_act;
        tout.col         = h_act ? 6'(hpos) : '0;
        tout.line        = v_act ? 8'(vpos) : '0;
        tout.frame_start = cen && (hpos == '0) && (vpos == '0);
    end
endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_en,
    output logic       hblank,
    output logic       vblank,
    output logic [5:0] col,
    output logic [7:0] line,
    output logic       frame_start
);
    localparam int unsigned H_W = $clog2(LINE_CYC);
    localparam int unsigned V_W = $clog2(FRAME_LINES);

    logic [H_W-1:0] hpos;
    logic [V_W-1:0] vpos;
    logic           line_end;
    raster_out_t    tout;

    raster_hcount #(.LINE_CYC(LINE_CYC)) u_h (
        .clk(clk), .rst(rst), .cen(cyc_en), .hpos(hpos), .line_end(line_end)
    );

    raster_vcount #(.FRAME_LINES(FRAME_LINES)) u_v (
        .clk(clk), .rst(rst), .adv(cyc_en && line_end), .vpos(vpos)
    );

    raster_decode #(.VIS_BYTES(VIS_BYTES), .VIS_LINES(VIS_LINES), .H_W(H_W), .V_W(V_W)) u_d (
        .cen(cyc_en), .hpos(hpos), .vpos(vpos), .tout(tout)
    );

    assign hblank      = tout.hblank;
    assign vblank      = tout.vblank;
    assign col         = tout.col;
    assign line        = tout.line;
    assign frame_start = tout.frame_start;

    // R1/R9: reset puts the outputs at the origin
    a_r9_reset_origin: assert property (@(posedge clk)
        rst |=> (!hblank && !vblank && col == '0 && line == '0));
    // R8: strobe only at the origin
    a_r8_sof_origin: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (!hblank && !vblank && col == '0 && line == '0));
    // R6: blanked lines report zero
    a_r6_vblank_zero: assert property (@(posedge clk) disable iff (rst)
        vblank |-> line == '0);
    // R4: blanked cycles report column zero
    a_r4_hblank_zero: assert property (@(posedge clk) disable iff (rst)
        hblank |-> col == '0);
    // R2: outputs hold without enable
    a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> ($stable(col) && $stable(line) && $stable(hblank) && $stable(vblank)));
endmodule

// File: tb/sim_raster_timing.sv
module sim_raster_timing;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_en = 1'b0;
    logic       hblank, vblank, frame_start;
    logic [5:0] col;
    logic [7:0] line;

    int vectors = 0;
    int errors  = 0;
    int m_h = 0;
    int m_v = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing u0 (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .hblank(hblank), .vblank(vblank),
        .col(col), .line(line), .frame_start(frame_start)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (h=%0d v=%0d)", req, act, exp, m_h, m_v);
        end
    endtask

    // one clock: drive at falling edge, compare, then step the model
    task automatic step(input bit r, input bit e);
        @(negedge clk);
        rst = r;
        cyc_en = e;
        #1;
        chk("R4 hblank", int'(hblank), (m_h >= 40) ? 1 : 0);
        chk("R3 col", int'(col), (m_h < 40) ? m_h : 0);
        chk("R6 vblank", int'(vblank), (m_v >= 192) ? 1 : 0);
        chk("R6 line", int'(line), (m_v < 192) ? m_v : 0);
        chk("R8 frame_start", int'(frame_start), (e && m_h == 0 && m_v == 0) ? 1 : 0);
        if (r) begin
            m_h = 0; m_v = 0;
        end else if (e) begin
            if (m_h == 64) begin
                m_h = 0;
                m_v = (m_v == 261) ? 0 : m_v + 1;
            end else begin
                m_h++;
            end
        end
    endtask

    initial begin
        int en_cnt, last_sof, sof_seen, hb_cnt, vb_cnt, vis_cnt;
        step(1, 0);
        step(1, 1);
        // R1: reset state
        chk("R1 reset col", int'(col), 0);
        chk("R1 reset line", int'(line), 0);
        chk("R1 reset blanks", int'({hblank, vblank}), 0);
        // R2: hold with enable low
        for (int i = 0; i < 10; i++) step(0, 0);
        chk("R2 hold col", int'(col), 0);
        // R3: count a few columns then idle
        for (int i = 0; i < 5; i++) step(0, 1);
        for (int i = 0; i < 4; i++) step(0, 0);
        chk("R2 held col", int'(col), 5);
        // R9: reset wins over enable
        step(1, 1);
        step(1, 1);
        step(0, 0);
        chk("R9 col after reset", int'(col), 0);
        // R5/R7/R8: run irregular enables across more than two frames
        en_cnt = 0; last_sof = -1; sof_seen = 0; hb_cnt = 0; vb_cnt = 0; vis_cnt = 0;
        for (int i = 0; i < 45000; i++) begin
            bit e;
            e = (($urandom % 5) != 0);
            step(0, e);
            if (e) begin
                if (frame_start) begin
                    if (last_sof >= 0) chk("R7 frame length", en_cnt - last_sof, 17030);
                    last_sof = en_cnt;
                    sof_seen++;
                end
                if (sof_seen == 1) begin
                    if (vblank) vb_cnt++;
                    else if (hblank) hb_cnt++;
                    else vis_cnt++;
                end
                en_cnt++;
            end
        end
        chk("R8 frame strobes", (sof_seen >= 2) ? 1 : 0, 1);
        chk("R6 vblank cycles", vb_cnt, 4550);
        chk("R4 hblank cycles", hb_cnt, 192 * 25);
        chk("R3 visible cycles", vis_cnt, 192 * 40);
        // R5: run to end of a line and check the advance
        while (!(m_h == 64 && m_v == 10)) step(0, 1);
        step(0, 1);
        step(0, 0);
        chk("R5 line advance", int'(line), 11);
        chk("R5 column wrap", int'(col), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (120000) @(posedge clk);
                errors++;
                vectors++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule